// File: doc/BRIEF.md
# Slot Presence and System Status Register File

This block is a small register file that a CPU reaches over a simple synchronous register bus. It reports which module slots are occupied, using an active-low pattern in which every slot appears in several bit positions. The layout of that pattern depends on whether the chassis is a four-slot or a seven-slot build. The block also returns a platform identifier chosen by a variant input and a few constant status words. It holds one writable 8-bit mask.

The block owns two level interrupts: module management and external. Each is raised by a one-cycle pulse from elsewhere in the chip and stays high until software reads the matching status register. Read data is registered and appears one cycle after the read strobe. The clearing side effect takes effect at the same clock edge that captures the read data.

Top module: `slot_status_regs`

## Requirements
- R1: After reset, read data is 0, both interrupt outputs are low and the mask register (address 8) reads 0.
- R2: With `wide_mode`=0, address 4 returns 0xFFFF with bits i, i+4, i+8 and i+12 cleared for each set `slot_present[i]`, i = 0..3. `slot_present[6:4]` has no effect on it, and address 5 returns 0.
- R3: With `wide_mode`=1, address 4 starts at 0xFFFF and is ANDed with 0xF0FF, 0xFFF0, 0x0FFF and 0xFF0F for set `slot_present[1]`..`slot_present[4]` respectively. Address 5 starts at 0xFFFF and is ANDed with 0xF0FF for `slot_present[5]` and 0xFFF0 for `slot_present[6]`. `slot_present[0]` has no effect on either word.
- R4: Address 3 returns the platform code in bits 7:5 and zeros elsewhere. `variant_sel` 0 gives code 0 (0x00), 1 gives code 4 (0x80), 2 gives code 3 (0x60) and 3 gives 0x00.
- R5: Address 0 returns 0x00FF, address 1 returns 0x1000 and address 2 returns 0x0021.
- R6: A write to address 8 stores `bus_wdata[7:0]`. A read of address 8 returns the stored value with zeros in bits 15:8.
- R7: A one-cycle `mgmt_set` pulse drives `mgmt_irq` high from the next cycle. A read of address 6 returns 0x0000 and drives `mgmt_irq` low from the cycle after the strobe.
- R8: A one-cycle `ext_set` pulse drives `ext_irq` high. A read of address 7 returns 0x0000 when `wide_mode`=0 and 0x0054 when `wide_mode`=1, and drives `ext_irq` low from the cycle after the strobe.
- R9: When a set pulse and the clearing read of the same interrupt fall in the same cycle, the interrupt is high afterwards.
- R10: `bus_rdata` is valid in the cycle after `bus_rd`. It is 0 in any cycle not preceded by a read strobe, and reads of addresses 9 to 15 return 0.
- R11: Writes to addresses other than 8 change no readable value and clear no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| slot_present | input | 7 | Per-slot occupancy, 1 = occupied |
| wide_mode | input | 1 | 0 = four-slot layout, 1 = seven-slot layout |
| variant_sel | input | 2 | Platform variant selector |
| mgmt_set | input | 1 | Management interrupt set pulse |
| ext_set | input | 1 | External interrupt set pulse |
| mgmt_irq | output | 1 | Management interrupt level |
| ext_irq | output | 1 | External interrupt level |

## Verification
The hardest case to reach from the ports is a set pulse that lands in the same cycle as the clearing read of the same status register. The interrupt must survive that collision. The bench drives both the read strobe and the set input at the same falling edge, so both are seen at one rising edge. It then checks that the line is still high, and that a later plain read still clears it. The presence encoders are swept over all 128 occupancy patterns in both layouts, so both the ignored slot inputs and every mask overlap are covered.

// File: rtl/slotreg_pkg.sv
package slotreg_pkg;
  localparam int unsigned DW           = 16;
  localparam int unsigned NARROW_SLOTS = 4;
  localparam int unsigned WIDE_SLOTS   = 7;
  localparam int unsigned MASK_W       = 8;
  localparam int unsigned IRQ_N        = 2;

  typedef enum logic [3:0] {
    RA_FLASH_PROT = 4'd0,
    RA_BOOT_SIZE  = 4'd1,
    RA_ENV        = 4'd2,
    RA_PLATFORM   = 4'd3,
    RA_PRES_LO    = 4'd4,
    RA_PRES_HI    = 4'd5,
    RA_MGMT_STAT  = 4'd6,
    RA_EXT_STAT   = 4'd7,
    RA_MASK       = 4'd8
  } reg_addr_e;

  localparam logic [DW-1:0] FLASH_PROT_VAL = 16'h00FF;
  localparam logic [DW-1:0] BOOT_SIZE_VAL  = 16'h1000;
  localparam logic [DW-1:0] ENV_VAL        = 16'h0021;
  localparam logic [DW-1:0] EXT_WIDE_VAL   = 16'h0054;

  // AND mask contributed by an occupied slot in the seven-slot layout
  function automatic logic [DW-1:0] wide_mask(input int unsigned slot);
    case (slot)
      1, 5:    wide_mask = 16'hF0FF;
      2, 6:    wide_mask = 16'hFFF0;
      3:       wide_mask = 16'h0FFF;
      4:       wide_mask = 16'hFF0F;
      default: wide_mask = 16'hFFFF;
    endcase
  endfunction

  function automatic logic [2:0] variant_code(input logic [1:0] v);
    case (v)
      2'd1:    variant_code = 3'd4;
      2'd2:    variant_code = 3'd3;
      default: variant_code = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/slot_presence_enc.sv
module slot_presence_enc
  import slotreg_pkg::*;
(
  input  logic                  wide_mode,
  input  logic [WIDE_SLOTS-1:0] present,
  output logic [DW-1:0]         word_lo,
  output logic [DW-1:0]         word_hi
);
  localparam int unsigned NIB = DW / 4;
  localparam logic [DW-1:0] REP = {NIB{4'b0001}};

  logic [DW-1:0] narrow_w, wide_a, wide_b;

  always_comb begin
    narrow_w = '1;
    for (int unsigned i = 0; i < NARROW_SLOTS; i++)
      if (present[i]) narrow_w = narrow_w & ~(REP << i);
  end

  always_comb begin
    wide_a = '1;
    wide_b = '1;
    for (int unsigned s = 1; s < WIDE_SLOTS; s++) begin
      if (present[s]) begin
        if (s <= 4) wide_a = wide_a & wide_mask(s);
        else        wide_b = wide_b & wide_mask(s);
      end
    end
  end

  assign word_lo = wide_mode ? wide_a : narrow_w;
  assign word_hi = wide_mode ? wide_b : '0;
endmodule

// File: rtl/irq_flag.sv
module irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o);
  assert_level_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/slot_status_regs.sv
module slot_status_regs
  import slotreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_rd,
  input  logic                  bus_wr,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  input  logic [WIDE_SLOTS-1:0] slot_present,
  input  logic                  wide_mode,
  input  logic [1:0]            variant_sel,
  input  logic                  mgmt_set,
  input  logic                  ext_set,
  output logic                  mgmt_irq,
  output logic                  ext_irq
);
  localparam int unsigned SEL_W = 4;

  logic             in_window;
  logic [SEL_W-1:0] sel;
  logic [DW-1:0]    pres_lo, pres_hi;
  logic [MASK_W-1:0] mask_q;
  logic [IRQ_N-1:0] set_vec, clr_vec, flag_vec;

  generate
    if (ADDR_W > SEL_W) begin : g_wide_addr
      assign in_window = (bus_addr[ADDR_W-1:SEL_W] == '0);
      assign sel       = bus_addr[SEL_W-1:0];
    end else begin : g_narrow_addr
      assign in_window = 1'b1;
      assign sel       = SEL_W'(bus_addr);
    end
  endgenerate

  slot_presence_enc u_pres (
    .wide_mode (wide_mode),
    .present   (slot_present),
    .word_lo   (pres_lo),
    .word_hi   (pres_hi)
  );

  assign set_vec = {ext_set, mgmt_set};
  assign clr_vec = {bus_rd && in_window && (sel == RA_EXT_STAT),
                    bus_rd && in_window && (sel == RA_MGMT_STAT)};

  generate
    for (genvar k = 0; k < IRQ_N; k++) begin : g_irq
      irq_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_vec[k]),
        .clr_i  (clr_vec[k]),
        .flag_o (flag_vec[k])
      );
    end
  endgenerate

  assign mgmt_irq = flag_vec[0];
  assign ext_irq  = flag_vec[1];

  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '0;
    else if (bus_wr && in_window && sel == RA_MASK)
      mask_q <= bus_wdata[MASK_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_rd || !in_window) begin
      bus_rdata <= '0;
    end else begin
      case (sel)
        RA_FLASH_PROT: bus_rdata <= FLASH_PROT_VAL;
        RA_BOOT_SIZE:  bus_rdata <= BOOT_SIZE_VAL;
        RA_ENV:        bus_rdata <= ENV_VAL;
        RA_PLATFORM:   bus_rdata <= DW'({variant_code(variant_sel), 5'b0});
        RA_PRES_LO:    bus_rdata <= pres_lo;
        RA_PRES_HI:    bus_rdata <= pres_hi;
        RA_MGMT_STAT:  bus_rdata <= '0;
        RA_EXT_STAT:   bus_rdata <= wide_mode ? EXT_WIDE_VAL : '0;
        RA_MASK:       bus_rdata <= DW'(mask_q);
        default:       bus_rdata <= '0;
      endcase
    end
  end

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel > RA_MASK) |=> bus_rdata == '0);
  assert_ro_write_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel != RA_MASK) |=> $stable(mask_q));
  assert_mask_upper_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == RA_MASK) |=> bus_rdata[DW-1:MASK_W] == '0);
  assert_narrow_count_R2: assert property (@(posedge clk) disable iff (rst)
    !wide_mode |-> $countones(~pres_lo) == 4 * $countones(slot_present[NARROW_SLOTS-1:0]));
  assert_wide_slot0_R3: assert property (@(posedge clk) disable iff (rst)
    (wide_mode && slot_present[WIDE_SLOTS-1:1] == '0) |-> (pres_lo == '1 && pres_hi == '1));
  assert_mgmt_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == RA_MGMT_STAT) |=> bus_rdata == '0);
endmodule

// File: tb/tb_slot_status_regs.sv
module tb_slot_status_regs;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [6:0] slot_present = '0;
  logic wide_mode = 1'b0;
  logic [1:0] variant_sel = '0;
  logic mgmt_set = 1'b0, ext_set = 1'b0, mgmt_irq, ext_irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_status_regs #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slot_present(slot_present),
    .wide_mode(wide_mode), .variant_sel(variant_sel), .mgmt_set(mgmt_set),
    .ext_set(ext_set), .mgmt_irq(mgmt_irq), .ext_irq(ext_irq));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  function automatic logic [15:0] exp_narrow(input logic [6:0] p);
    logic [15:0] r = 16'hFFFF;
    for (int i = 0; i < 4; i++) if (p[i]) r &= ~(16'h1111 << i);
    return r;
  endfunction

  function automatic logic [15:0] smask(input int s);
    case (s)
      1, 5: return 16'hF0FF;
      2, 6: return 16'hFFF0;
      3: return 16'h0FFF;
      default: return 16'hFF0F;
    endcase
  endfunction

  initial begin
    logic [15:0] d;
    logic [15:0] ea, eb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rdata", bus_rdata, 16'h0);
    chk("R1 mgmt_irq", {15'b0, mgmt_irq}, 16'h0);
    chk("R1 ext_irq", {15'b0, ext_irq}, 16'h0);
    rd(4'd8, d); chk("R1 mask", d, 16'h0);
    // R10 idle cycle after a read
    @(negedge clk); chk("R10 idle", bus_rdata, 16'h0);

    // R2 / R3 sweeps
    for (int m = 0; m < 2; m++) begin
      wide_mode = m[0];
      for (int p = 0; p < 128; p++) begin
        slot_present = p[6:0];
        if (m == 0) begin
          ea = exp_narrow(p[6:0]); eb = 16'h0;
        end else begin
          ea = 16'hFFFF; eb = 16'hFFFF;
          for (int s = 1; s < 7; s++)
            if (p[s]) begin
              if (s <= 4) ea &= smask(s); else eb &= smask(s);
            end
        end
        rd(4'd4, d); chk(m == 0 ? "R2 lo" : "R3 lo", d, ea);
        rd(4'd5, d); chk(m == 0 ? "R2 hi" : "R3 hi", d, eb);
      end
    end
    wide_mode = 1'b0; slot_present = '0;

    // R4 platform code
    for (int v = 0; v < 4; v++) begin
      variant_sel = v[1:0];
      rd(4'd3, d);
      chk("R4 platform", d, v == 1 ? 16'h0080 : (v == 2 ? 16'h0060 : 16'h0000));
    end

    // R5 fixed values
    rd(4'd0, d); chk("R5 flash", d, 16'h00FF);
    rd(4'd1, d); chk("R5 boot", d, 16'h1000);
    rd(4'd2, d); chk("R5 env", d, 16'h0021);

    // R6 mask sweep
    for (int v = 0; v < 256; v++) begin
      wr(4'd8, {~v[7:0], v[7:0]});
      rd(4'd8, d); chk("R6 mask", d, {8'h00, v[7:0]});
    end

    // R10 unmapped reads
    for (int a = 9; a < 16; a++) begin
      rd(a[3:0], d); chk("R10 unmapped", d, 16'h0);
    end

    // R11 writes elsewhere are ignored
    wr(4'd8, 16'h005A);
    @(negedge clk); mgmt_set = 1'b1; ext_set = 1'b1;
    @(negedge clk); mgmt_set = 1'b0; ext_set = 1'b0;
    for (int a = 0; a < 16; a++)
      if (a != 8) wr(a[3:0], 16'hA5A5);
    rd(4'd8, d); chk("R11 mask kept", d, 16'h005A);
    rd(4'd0, d); chk("R11 flash kept", d, 16'h00FF);
    rd(4'd2, d); chk("R11 env kept", d, 16'h0021);
    chk("R11 mgmt kept", {15'b0, mgmt_irq}, 16'h1);
    chk("R11 ext kept", {15'b0, ext_irq}, 16'h1);

    // R7 management clear on read
    rd(4'd6, d); chk("R7 read value", d, 16'h0);
    chk("R7 cleared", {15'b0, mgmt_irq}, 16'h0);
    chk("R7 ext untouched", {15'b0, ext_irq}, 16'h1);

    // R8 external clear on read, both layouts
    rd(4'd7, d); chk("R8 narrow value", d, 16'h0);
    chk("R8 cleared", {15'b0, ext_irq}, 16'h0);
    wide_mode = 1'b1;
    @(negedge clk); ext_set = 1'b1;
    @(negedge clk); ext_set = 1'b0;
    chk("R8 raised", {15'b0, ext_irq}, 16'h1);
    rd(4'd7, d); chk("R8 wide value", d, 16'h0054);
    chk("R8 cleared wide", {15'b0, ext_irq}, 16'h0);

    // R9 set and clearing read in the same cycle
    @(negedge clk); bus_addr = 4'd6; bus_rd = 1'b1; mgmt_set = 1'b1;
    @(negedge clk); bus_rd = 1'b0; mgmt_set = 1'b0;
    chk("R9 mgmt survives", {15'b0, mgmt_irq}, 16'h1);
    chk("R9 read value", bus_rdata, 16'h0);
    @(negedge clk); bus_addr = 4'd7; bus_rd = 1'b1; ext_set = 1'b1;
    @(negedge clk); bus_rd = 1'b0; ext_set = 1'b0;
    chk("R9 ext survives", {15'b0, ext_irq}, 16'h1);
    rd(4'd6, d); chk("R9 later clear", {15'b0, mgmt_irq}, 16'h0);
    rd(4'd7, d); chk("R9 later clear ext", {15'b0, ext_irq}, 16'h0);

    // R7 set pulse timing
    @(negedge clk); mgmt_set = 1'b1;
    @(negedge clk); mgmt_set = 1'b0;
    chk("R7 raised", {15'b0, mgmt_irq}, 16'h1);
    @(negedge clk); chk("R7 holds", {15'b0, mgmt_irq}, 16'h1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule